// File: doc/BRIEF.md
# Card Data Path FIFO Engine

This block sits between a host that moves 32-bit words and a card data port that moves one byte at a time. A 16-word FIFO holds the data in transit. Software first writes a byte length, then starts a transfer by pulsing a start input together with a direction bit. In the receive direction the engine takes bytes from the card whenever the card says data is ready and the FIFO has room. It packs four bytes into each word, lowest byte first, and pushes the words for the host to pop. In the transmit direction the host pushes words. The engine pops each word and sends its bytes to the card, least-significant byte first.

A down-counter tracks the bytes still to move, and a rounded-up word count is derived from it. When the counter reaches zero the transfer is marked done. The engine stays enabled until the FIFO has also drained. Occupancy flags are reported only for the direction in use, and only while the engine is enabled. Two sticky error flags record a host push into a full FIFO and a host pop from an empty FIFO.

Top module: `card_fifo_engine`

## Requirements
- R1: The FIFO stores up to 16 words of 32 bits and returns them in push order. `fifo_level` gives the current occupancy from 0 to 16. Read data appears on `host_rdata` in the cycle after an accepted pop.
- R2: With `ctl_dir`=1 (receive), the k-th byte taken from the card (k = 0..3 within a word) lands in bits 8k+7..8k of the word. A word is pushed each time four bytes have been gathered.
- R3: If the byte count reaches zero part-way through a word during receive, the partial word is still pushed, with its unfilled upper bytes zero.
- R4: With `ctl_dir`=0 (transmit), each popped word is sent on `card_wr_data` least-significant byte first, one byte per `card_wr_strb` pulse. Bytes of the last word that lie beyond the byte count are never sent.
- R5: `card_rd_strb` pulses only while receiving with a nonzero count, `card_rd_ready` high and the FIFO not full. At most one byte moves per clock in either direction.
- R6: `ctl_start` loads the remaining count `xfer_count` from the last value written through `cfg_len`. The count drops by one for each byte moved. `word_count` equals (`xfer_count` + 3) >> 2.
- R7: `xfer_done` sets once the count is zero while enabled, and clears on the next start. `xfer_en` clears by itself only when the count is zero and the FIFO is empty. A start with length zero finishes with no byte moved.
- R8: Transmit flags (`tx_active`, `tx_avail`, `tx_empty`, `tx_full`, `tx_half_empty`) are driven only while enabled in transmit. Receive flags (`rx_active`, `rx_avail`, `rx_empty`, `rx_full`, `rx_half_full`) are driven only while enabled in receive. Empty means level 0, avail means level nonzero, full means level 16, half-empty means level ≤ 8 and half-full means level ≥ 8. All flags are 0 while idle.
- R9: A host push is accepted only while transmitting with a nonzero count, and is ignored otherwise. An accepted push into a full FIFO is dropped and sets the sticky `overrun`, which the next start clears.
- R10: A host pop is ignored while transmitting with a nonzero count. Any other host pop on an empty FIFO returns zero and sets the sticky `underrun`, which the next start clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len_we | input | 1 | Write strobe for the length register |
| cfg_len | input | 16 | Transfer length in bytes |
| ctl_start | input | 1 | Start pulse; loads the count, latches direction |
| ctl_dir | input | 1 | 1 = receive from card, 0 = transmit to card |
| host_push | input | 1 | Host word push |
| host_wdata | input | 32 | Pushed word |
| host_pop | input | 1 | Host word pop |
| host_rdata | output | 32 | Popped word, valid the cycle after the pop |
| card_rd_ready | input | 1 | Card has a byte ready |
| card_rd_data | input | 8 | Byte from the card, taken while card_rd_strb is high |
| card_rd_strb | output | 1 | Byte taken from the card this cycle |
| card_wr_strb | output | 1 | Byte on card_wr_data is valid this cycle |
| card_wr_data | output | 8 | Byte to the card |
| xfer_en | output | 1 | Engine enabled |
| xfer_done | output | 1 | Byte count reached zero |
| xfer_count | output | 16 | Bytes remaining |
| word_count | output | 15 | Remaining bytes rounded up to words |
| fifo_level | output | 5 | FIFO occupancy |
| tx_active | output | 1 | Transmit in progress |
| tx_avail | output | 1 | Transmit FIFO holds data |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| tx_half_empty | output | 1 | Transmit FIFO at most half full |
| rx_active | output | 1 | Receive in progress |
| rx_avail | output | 1 | Receive FIFO holds data |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| rx_half_full | output | 1 | Receive FIFO at least half full |
| overrun | output | 1 | Sticky: push dropped on a full FIFO |
| underrun | output | 1 | Sticky: pop on an empty FIFO |

## Verification
Receive runs with a multiple of four bytes, with a length that ends mid-word, and with a 70-byte length that fills the FIFO. The first shows byte-lane order. The second shows zero filling of a partial word. The third shows back-pressure stopping the card strobe at exactly six bytes left, and FIFO order being kept across stall and resume. A transmit of six bytes from two words tells least-significant-first order apart from dropping the tail. Host accesses in the wrong phase, a flood of pushes, a pop on an empty FIFO and a zero-length start separate the ignore, overrun, underrun and immediate-done paths.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/cfe_fifo.sv
module cfe_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CW-1:0]     level,
  output logic              full,
  output logic              empty,
  output logic              ovf,
  output logic              udf
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              do_wr, do_rd;

  assign full  = (level == CW'(DEPTH));
  assign empty = (level == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign ovf   = wr_en && full;
  assign udf   = rd_en && empty;

  // storage written without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      level   <= '0;
      rd_data <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd_en) rd_data <= empty ? '0 : mem[rptr];
      if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (level == CW'(DEPTH))); // R9
  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> (rd_data == '0)); // R10
endmodule

// File: rtl/cfe_rx_pack.sv
module cfe_rx_pack #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = DATA_W / BYTE_W,
  localparam int IW    = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              last,
  output logic              push,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] acc;
  logic [IW-1:0]     bidx;

  always_comb begin
    word = acc | (DATA_W'(byte_in) << (BYTE_W * bidx));
    push = byte_vld && ((bidx == IW'(NB - 1)) || last);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc  <= '0;
      bidx <= '0;
    end else if (byte_vld) begin
      if (push) begin
        acc  <= '0;
        bidx <= '0;
      end else begin
        acc  <= word;
        bidx <= bidx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfe_tx_unpack.sv
module cfe_tx_unpack #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = DATA_W / BYTE_W,
  localparam int NW    = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              run,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] rd_word,
  output logic              pop,
  output logic              emit,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_out
);
  logic              pend;
  logic [NW-1:0]     nleft;
  logic [DATA_W-1:0] shreg;

  assign pop  = run && !clear && !pend && (nleft == '0) && !fifo_empty;
  assign emit = run && !clear && (pend || (nleft != '0));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pend     <= 1'b0;
      nleft    <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      byte_out <= '0;
    end else begin
      byte_vld <= emit;
      if (pop) pend <= 1'b1;
      if (emit && pend) begin
        pend     <= 1'b0;
        byte_out <= rd_word[BYTE_W-1:0];
        shreg    <= rd_word >> BYTE_W;
        nleft    <= NW'(NB - 1);
      end else if (emit) begin
        byte_out <= shreg[BYTE_W-1:0];
        shreg    <= shreg >> BYTE_W;
        nleft    <= nleft - 1'b1;
      end
    end
  end

  AST_POP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(pop && emit)); // R5
endmodule

// File: rtl/card_fifo_engine.sv
module card_fifo_engine #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 16,
  localparam int NB    = DATA_W / BYTE_W,
  localparam int SH    = $clog2(NB),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int WC_W  = LEN_W + 1 - SH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_len_we,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              ctl_start,
  input  logic              ctl_dir,
  input  logic              host_push,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_pop,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              card_rd_ready,
  input  logic [BYTE_W-1:0] card_rd_data,
  output logic              card_rd_strb,
  output logic              card_wr_strb,
  output logic [BYTE_W-1:0] card_wr_data,
  output logic              xfer_en,
  output logic              xfer_done,
  output logic [LEN_W-1:0]  xfer_count,
  output logic [WC_W-1:0]   word_count,
  output logic [CW-1:0]     fifo_level,
  output logic              tx_active,
  output logic              tx_avail,
  output logic              tx_empty,
  output logic              tx_full,
  output logic              tx_half_empty,
  output logic              rx_active,
  output logic              rx_avail,
  output logic              rx_empty,
  output logic              rx_full,
  output logic              rx_half_full,
  output logic              overrun,
  output logic              underrun
);
  import cfe_pkg::*;

  logic [LEN_W-1:0]  len_q;
  xfer_dir_e         dir_q;
  logic              cnt_zero, rx_take, tx_run;
  logic              pk_push, up_pop, up_emit;
  logic [DATA_W-1:0] pk_word;
  logic              f_wr, f_rd, f_full, f_empty, f_ovf, f_udf;

  assign cnt_zero     = (xfer_count == '0);
  assign tx_run       = xfer_en && (dir_q == DIR_TX) && !cnt_zero;
  assign rx_take      = xfer_en && (dir_q == DIR_RX) && !cnt_zero
                        && card_rd_ready && !f_full;
  assign card_rd_strb = rx_take;

  assign f_wr = pk_push || (host_push && tx_run);
  assign f_rd = up_pop  || (host_pop && !tx_run);

  cfe_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk, .rst,
    .wr_en(f_wr), .wr_data(pk_push ? pk_word : host_wdata),
    .rd_en(f_rd), .rd_data(host_rdata),
    .level(fifo_level), .full(f_full), .empty(f_empty),
    .ovf(f_ovf), .udf(f_udf)
  );

  cfe_rx_pack #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_pack (
    .clk, .rst, .clear(ctl_start),
    .byte_vld(rx_take), .byte_in(card_rd_data),
    .last(xfer_count == LEN_W'(1)),
    .push(pk_push), .word(pk_word)
  );

  cfe_tx_unpack #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_unpack (
    .clk, .rst, .clear(ctl_start), .run(tx_run),
    .fifo_empty(f_empty), .rd_word(host_rdata),
    .pop(up_pop), .emit(up_emit),
    .byte_vld(card_wr_strb), .byte_out(card_wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q      <= '0;
      dir_q      <= DIR_TX;
      xfer_en    <= 1'b0;
      xfer_done  <= 1'b0;
      xfer_count <= '0;
      overrun    <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      if (cfg_len_we) len_q <= cfg_len;
      if (ctl_start) begin
        xfer_count <= len_q;
        dir_q      <= xfer_dir_e'(ctl_dir);
        xfer_en    <= 1'b1;
        xfer_done  <= 1'b0;
        overrun    <= 1'b0;
        underrun   <= 1'b0;
      end else begin
        if (rx_take || up_emit) xfer_count <= xfer_count - 1'b1;
        if (xfer_en && cnt_zero) xfer_done <= 1'b1;
        if (xfer_en && cnt_zero && f_empty) xfer_en <= 1'b0;
        if (f_ovf) overrun  <= 1'b1;
        if (f_udf) underrun <= 1'b1;
      end
    end
  end

  assign word_count = WC_W'(((LEN_W+1)'(xfer_count) + (LEN_W+1)'(NB - 1)) >> SH);

  always_comb begin
    tx_active     = xfer_en && (dir_q == DIR_TX);
    rx_active     = xfer_en && (dir_q == DIR_RX);
    tx_avail      = tx_active && !f_empty;
    tx_empty      = tx_active && f_empty;
    tx_full       = tx_active && f_full;
    tx_half_empty = tx_active && (fifo_level <= CW'(DEPTH / 2));
    rx_avail      = rx_active && !f_empty;
    rx_empty      = rx_active && f_empty;
    rx_full       = rx_active && f_full;
    rx_half_full  = rx_active && (fifo_level >= CW'(DEPTH / 2));
  end

  AST_PACK_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
    pk_push |-> !f_full); // R5
  AST_ONE_BYTE_DIR: assert property (@(posedge clk) disable iff (rst)
    $onehot0({card_rd_strb, up_emit})); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    ((rx_take || up_emit) && !ctl_start) |=> (xfer_count == $past(xfer_count) - 1'b1)); // R6
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && cnt_zero && !ctl_start) |=> xfer_done); // R7
  AST_IDLE_WHEN_DRAINED: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && cnt_zero && f_empty && !ctl_start) |=> !xfer_en); // R7
  AST_FLAG_DIR: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_active, rx_active})); // R8
endmodule

// File: tb/card_fifo_engine_tb.sv
module card_fifo_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_len_we = 1'b0;
  logic [15:0] cfg_len = '0;
  logic        ctl_start = 1'b0, ctl_dir = 1'b0;
  logic        host_push = 1'b0, host_pop = 1'b0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        card_rd_ready = 1'b0;
  logic [7:0]  card_rd_data;
  logic        card_rd_strb, card_wr_strb;
  logic [7:0]  card_wr_data;
  logic        xfer_en, xfer_done;
  logic [15:0] xfer_count;
  logic [14:0] word_count;
  logic [4:0]  fifo_level;
  logic        tx_active, tx_avail, tx_empty, tx_full, tx_half_empty;
  logic        rx_active, rx_avail, rx_empty, rx_full, rx_half_full;
  logic        overrun, underrun;

  int checks = 0, failures = 0, cycles = 0;
  int rx_idx = 0, txn = 0;
  logic [7:0] txq [256];

  always #5 clk = ~clk;

  card_fifo_engine u_dut (.*);

  function automatic logic [7:0] bv(int i);
    return 8'(i + 16);
  endfunction
  function automatic logic [31:0] wv(int s, int n);
    logic [31:0] w = '0;
    for (int k = 0; k < n; k++) w[8*k +: 8] = bv(s + k);
    return w;
  endfunction

  assign card_rd_data = bv(rx_idx);
  always @(posedge clk) if (card_rd_strb) rx_idx <= rx_idx + 1;
  always @(negedge clk) if (card_wr_strb) begin
    txq[txn[7:0]] <= card_wr_data;
    txn <= txn + 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(int len, logic dir);
    @(negedge clk); cfg_len = 16'(len); cfg_len_we = 1'b1;
    @(negedge clk); cfg_len_we = 1'b0; ctl_start = 1'b1; ctl_dir = dir;
    @(negedge clk); ctl_start = 1'b0;
  endtask

  task automatic hpush(logic [31:0] w);
    host_wdata = w; host_push = 1'b1;
    @(negedge clk); host_push = 1'b0;
  endtask

  task automatic hpop(output logic [31:0] w);
    host_pop = 1'b1;
    @(negedge clk); host_pop = 1'b0;
    w = host_rdata;
  endtask

  task automatic t_reset;
    chk("R1 reset level", 32'(fifo_level), 0);
    chk("R7 reset en", 32'(xfer_en), 0);
    chk("R8 reset flags", 32'({tx_active, tx_empty, rx_active, rx_empty, xfer_done}), 0);
    chk("R6 reset word_count", 32'(word_count), 0);
  endtask

  task automatic t_rx_words;
    int s = rx_idx;
    logic [31:0] w;
    card_rd_ready = 1'b1;
    start(8, 1'b1);
    idle(20);
    chk("R1 rx level", 32'(fifo_level), 2);
    chk("R7 rx done", 32'({xfer_done, xfer_en}), 32'b11);
    chk("R8 rx flags", 32'({rx_active, rx_avail, rx_empty, rx_full, rx_half_full, tx_active}),
        32'b110000);
    hpop(w); chk("R2 rx word0", w, wv(s, 4));
    hpop(w); chk("R2 rx word1", w, wv(s + 4, 4));
    idle(2);
    chk("R7 rx idle after drain", 32'({xfer_en, rx_active}), 0);
  endtask

  task automatic t_rx_partial;
    int s = rx_idx;
    logic [31:0] w;
    card_rd_ready = 1'b0;
    start(6, 1'b1);
    idle(5);
    chk("R5 no strobe when not ready", 32'(rx_idx), 32'(s));
    chk("R6 count loaded", 32'(xfer_count), 6);
    chk("R6 word_count", 32'(word_count), 2);
    card_rd_ready = 1'b1;
    idle(15);
    hpop(w); chk("R2 partial word0", w, wv(s, 4));
    hpop(w); chk("R3 partial word1", w, wv(s + 4, 2));
  endtask

  task automatic t_rx_backpressure;
    int s = rx_idx;
    logic [31:0] w;
    card_rd_ready = 1'b1;
    start(70, 1'b1);
    idle(100);
    chk("R5 stall count", 32'(xfer_count), 6);
    chk("R6 stall word_count", 32'(word_count), 2);
    chk("R8 rx full flags", 32'({rx_full, rx_half_full, rx_avail, rx_empty}), 32'b1110);
    chk("R1 full level", 32'(fifo_level), 16);
    for (int j = 0; j < 18; j++) begin
      hpop(w);
      chk("R1 ordered word", w, wv(s + 4*j, (j == 17) ? 2 : 4));
      idle(6);
    end
    chk("R7 drained idle", 32'({xfer_en, fifo_level}), 0);
  endtask

  task automatic t_tx;
    int n0;
    logic [31:0] w;
    card_rd_ready = 1'b0;
    start(6, 1'b0);
    idle(3);
    chk("R8 tx flags", 32'({tx_active, tx_avail, tx_empty, tx_full, tx_half_empty, rx_active}),
        32'b101010);
    hpop(w);
    idle(1);
    chk("R10 pop ignored in tx", 32'({underrun, fifo_level}), 0);
    n0 = txn;
    hpush(32'hA1B2C3D4);
    hpush(32'h01020304);
    idle(30);
    chk("R4 tx byte count", 32'(txn - n0), 6);
    chk("R4 tx b0", 32'(txq[8'(n0)]), 32'hD4);
    chk("R4 tx b1", 32'(txq[8'(n0 + 1)]), 32'hC3);
    chk("R4 tx b3", 32'(txq[8'(n0 + 3)]), 32'hA1);
    chk("R4 tx b4", 32'(txq[8'(n0 + 4)]), 32'h04);
    chk("R4 tx b5", 32'(txq[8'(n0 + 5)]), 32'h03);
    chk("R7 tx finished", 32'({xfer_done, xfer_en, xfer_count}), 32'h20000);
  endtask

  task automatic t_overrun;
    logic [31:0] w;
    start(200, 1'b0);
    for (int j = 0; j < 24; j++) hpush(32'(j));
    chk("R9 overrun set", 32'(overrun), 1);
    start(0, 1'b0);
    chk("R9 overrun cleared by start", 32'(overrun), 0);
    for (int j = 0; j < 16; j++) if (fifo_level != 0) hpop(w);
    idle(2);
    chk("R7 idle after drain", 32'({xfer_en, fifo_level}), 0);
  endtask

  task automatic t_idle_access;
    logic [31:0] w;
    hpush(32'hDEADBEEF);
    idle(1);
    chk("R9 push ignored idle", 32'(fifo_level), 0);
    hpop(w);
    chk("R10 empty pop zero", w, 0);
    chk("R10 underrun set", 32'(underrun), 1);
  endtask

  task automatic t_zero_len;
    int s = rx_idx;
    card_rd_ready = 1'b1;
    start(0, 1'b1);
    idle(3);
    chk("R7 zero len", 32'({xfer_done, xfer_en, xfer_count}), 32'h20000);
    chk("R10 underrun cleared", 32'(underrun), 0);
    chk("R7 zero len no byte", 32'(rx_idx), 32'(s));
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_rx_words();
    t_rx_partial();
    t_rx_backpressure();
    t_tx();
    t_overrun();
    t_idle_access();
    t_zero_len();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule